// File: doc/BRIEF.md
# Condition Code Flag Generator

This block sits beside the integer datapath of a processor. Each cycle it takes an operation class and two 32-bit operands. It forms the add or subtract result where the class needs one, and it works out the next carry, overflow, zero, negative and extend flags. The result is available combinationally on `res_o`. The five flags are held in a register that loads only when the update strobe `upd_i` is high. That register also supplies the previous flags the next operation needs: the extend flag acts as carry or borrow in, and the zero flag is the sticky input for extended arithmetic.

Three classes are pass-through. For logic and shift the value to be flagged arrives on `op_a_i` and is returned unchanged. A shift also supplies its own carry-out bit on `sh_carry_i`. Compares subtract at full width for the result output, but take their flags from the low byte or the low half-word only.

Top module: `ccg_flags_top`

## Requirements
- R1: While `rst_n` is low, and after it rises, `ccr_o` is 5'b00000.
- R2: `ccr_o` packs the flags as X=bit 4, N=bit 3, Z=bit 2, V=bit 1, C=bit 0. It loads the newly computed flags on a rising clock edge where `upd_i` is 1, and it holds its value when `upd_i` is 0.
- R3: Class 3'd1 (add): `res_o` = a+b mod 2^32. C is set when `res_o` < b unsigned. V is set when a and b have equal sign bits and the sign of `res_o` differs from them. X takes the new C.
- R4: Class 3'd2 (subtract): `res_o` = a-b mod 2^32. C is set when a < b unsigned. V is set when a and b differ in sign and the sign of `res_o` differs from a. X takes the new C.
- R5: Class 3'd3 (add with extend): `res_o` = a+b+X, where X is the registered bit 4. When X=1, C is set when `res_o` <= b; when X=0, C is set when `res_o` < b. V follows the add rule and X takes the new C.
- R6: Class 3'd4 (subtract with extend): `res_o` = a-b-X. When X=1, C is set when a <= b; when X=0, C is set when a < b. V follows the subtract rule and X takes the new C.
- R7: For classes 3'd3 and 3'd4, the new Z is the old Z ANDed with (`res_o`==0). A non-zero result clears Z and a zero result leaves it as it was.
- R8: For every other class, Z is set exactly when the flagged value is zero at the class's width. N is the top bit of that value at that width. N and Z are never both set.
- R9: Classes 3'd5 (byte compare) and 3'd6 (word compare) compute N, Z, V and C by the subtract rules on the low 8 or 16 bits of a, b and a-b. `res_o` is the full a-b, and X is left unchanged.
- R10: Class 3'd0 (logic): `res_o` = a. N and Z come from a, V and C are cleared, and X is left unchanged.
- R11: Class 3'd7 (shift): `res_o` = a. N and Z come from a, V is cleared, C = `sh_carry_i`, and X takes the new C.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| upd_i | input | 1 | Load the computed flags into the register |
| op_i | input | 3 | Operation class code |
| op_a_i | input | 32 | First operand, or the value to flag for logic and shift |
| op_b_i | input | 32 | Second (source) operand |
| sh_carry_i | input | 1 | Carry-out bit from the shifter |
| res_o | output | 32 | Add or subtract result, or op_a_i passed through |
| ccr_o | output | 5 | Registered flags {X,N,Z,V,C} |

## Verification
The main function is tried with several kinds of operand:
- Wrap-around sums that separate carry from overflow.
- Equal operands, which tell the less-or-equal extended carry apart from the strict one.
- Chains of extended operations, which show whether Z is sticky or recomputed.
- Compare operands whose upper bits disagree with their low byte or half-word, which show whether the narrow width is really used.

A long stretch of random classes, operands and strobes is then compared against a behavioural model on every clock. That run checks flag retention and X feedback in both states.

// File: rtl/ccg_pkg.sv
package ccg_pkg;

    typedef enum logic [2:0] {
        CC_LOGIC = 3'd0,
        CC_ADD   = 3'd1,
        CC_SUB   = 3'd2,
        CC_ADDX  = 3'd3,
        CC_SUBX  = 3'd4,
        CC_CMPB  = 3'd5,
        CC_CMPW  = 3'd6,
        CC_SHIFT = 3'd7
    } cc_op_e;

    typedef struct packed {
        logic x;
        logic n;
        logic z;
        logic v;
        logic c;
    } cc_flags_t;

    localparam int unsigned CC_FLAG_W = $bits(cc_flags_t);

endpackage

// File: rtl/ccg_addsub.sv
// Add/subtract slice of parameterised width with carry-in; reports flag-ready
// carry/borrow, signed overflow, sign and zero of its result.
module ccg_addsub #(
    parameter int unsigned W = 32
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         sub_i,
    input  logic         cin_i,
    output logic [W-1:0] res_o,
    output logic         cflag_o,
    output logic         ovf_o,
    output logic         neg_o,
    output logic         zero_o
);
    logic [W-1:0] b_eff;
    logic         cout;

    always_comb begin
        b_eff          = sub_i ? ~b_i : b_i;
        {cout, res_o}  = {1'b0, a_i} + {1'b0, b_eff} + {{W{1'b0}}, cin_i};
        // For subtraction a borrow is the absence of a carry out
        cflag_o        = sub_i ? ~cout : cout;
        ovf_o          = (a_i[W-1] == b_eff[W-1]) && (res_o[W-1] != a_i[W-1]);
        neg_o          = res_o[W-1];
        zero_o         = (res_o == '0);
    end
endmodule

// File: rtl/ccg_flag_sel.sv
// Chooses the next flag set for the operation class.
module ccg_flag_sel
    import ccg_pkg::*;
#(
    parameter int unsigned DW = 32
) (
    input  cc_op_e        op_i,
    input  cc_flags_t     prev_i,
    input  logic [DW-1:0] pass_i,
    input  logic          sh_carry_i,
    input  logic          m_c_i,
    input  logic          m_v_i,
    input  logic          m_n_i,
    input  logic          m_z_i,
    input  logic [1:0]    nr_c_i,
    input  logic [1:0]    nr_v_i,
    input  logic [1:0]    nr_n_i,
    input  logic [1:0]    nr_z_i,
    output cc_flags_t     next_o
);
    logic pass_zero;
    logic pass_neg;

    assign pass_zero = (pass_i == '0);
    assign pass_neg  = pass_i[DW-1];

    always_comb begin
        next_o = prev_i;
        unique case (op_i)
            CC_LOGIC: begin
                next_o.n = pass_neg;
                next_o.z = pass_zero;
                next_o.v = 1'b0;
                next_o.c = 1'b0;
            end
            CC_ADD, CC_SUB: begin
                next_o.n = m_n_i;
                next_o.z = m_z_i;
                next_o.v = m_v_i;
                next_o.c = m_c_i;
                next_o.x = m_c_i;
            end
            CC_ADDX, CC_SUBX: begin
                next_o.n = m_n_i;
                next_o.z = prev_i.z & m_z_i;
                next_o.v = m_v_i;
                next_o.c = m_c_i;
                next_o.x = m_c_i;
            end
            CC_CMPB: begin
                next_o.n = nr_n_i[0];
                next_o.z = nr_z_i[0];
                next_o.v = nr_v_i[0];
                next_o.c = nr_c_i[0];
            end
            CC_CMPW: begin
                next_o.n = nr_n_i[1];
                next_o.z = nr_z_i[1];
                next_o.v = nr_v_i[1];
                next_o.c = nr_c_i[1];
            end
            CC_SHIFT: begin
                next_o.n = pass_neg;
                next_o.z = pass_zero;
                next_o.v = 1'b0;
                next_o.c = sh_carry_i;
                next_o.x = sh_carry_i;
            end
            default: next_o = prev_i;
        endcase
    end
endmodule

// File: rtl/ccg_flags_top.sv
module ccg_flags_top
    import ccg_pkg::*;
#(
    parameter int unsigned DW = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 upd_i,
    input  logic [2:0]           op_i,
    input  logic [DW-1:0]        op_a_i,
    input  logic [DW-1:0]        op_b_i,
    input  logic                 sh_carry_i,
    output logic [DW-1:0]        res_o,
    output logic [CC_FLAG_W-1:0] ccr_o
);
    localparam int unsigned NARROW_N = 2;   // byte and word compare slices

    cc_op_e    op;
    cc_flags_t flags_q;
    cc_flags_t flags_d;
    logic      is_sub;
    logic      cin;
    logic      use_adder;
    logic [DW-1:0] sum;
    logic      m_c, m_v, m_n, m_z;
    logic [NARROW_N-1:0] nr_c, nr_v, nr_n, nr_z;

    assign op = cc_op_e'(op_i);

    always_comb begin
        is_sub    = (op == CC_SUB) || (op == CC_SUBX) || (op == CC_CMPB) || (op == CC_CMPW);
        use_adder = (op != CC_LOGIC) && (op != CC_SHIFT);
        unique case (op)
            CC_ADDX: cin = flags_q.x;
            CC_SUBX: cin = ~flags_q.x;
            CC_ADD:  cin = 1'b0;
            default: cin = is_sub;
        endcase
    end

    ccg_addsub #(.W(DW)) u_main (
        .a_i    (op_a_i),
        .b_i    (op_b_i),
        .sub_i  (is_sub),
        .cin_i  (cin),
        .res_o  (sum),
        .cflag_o(m_c),
        .ovf_o  (m_v),
        .neg_o  (m_n),
        .zero_o (m_z)
    );

    // Narrow compare slices: width 8 << g
    for (genvar g = 0; g < NARROW_N; g++) begin : g_narrow
        localparam int unsigned NW = 8 << g;
        logic [NW-1:0] nres;
        ccg_addsub #(.W(NW)) u_cmp (
            .a_i    (op_a_i[NW-1:0]),
            .b_i    (op_b_i[NW-1:0]),
            .sub_i  (1'b1),
            .cin_i  (1'b1),
            .res_o  (nres),
            .cflag_o(nr_c[g]),
            .ovf_o  (nr_v[g]),
            .neg_o  (nr_n[g]),
            .zero_o (nr_z[g])
        );
    end

    ccg_flag_sel #(.DW(DW)) u_sel (
        .op_i      (op),
        .prev_i    (flags_q),
        .pass_i    (op_a_i),
        .sh_carry_i(sh_carry_i),
        .m_c_i     (m_c),
        .m_v_i     (m_v),
        .m_n_i     (m_n),
        .m_z_i     (m_z),
        .nr_c_i    (nr_c),
        .nr_v_i    (nr_v),
        .nr_n_i    (nr_n),
        .nr_z_i    (nr_z),
        .next_o    (flags_d)
    );

    assign res_o = use_adder ? sum : op_a_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     flags_q <= '0;
        else if (upd_i) flags_q <= flags_d;
    end

    assign ccr_o = flags_q;

    // R2
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_i |=> $stable(ccr_o));

    // R8
    nz_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(ccr_o[3] && ccr_o[2]));

    // R7
    sticky_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_i && (op_i == 3'd3 || op_i == 3'd4) && !ccr_o[2]) |=> !ccr_o[2]);

    // R10
    logic_clears_vc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_i && op_i == 3'd0) |=> (ccr_o[1:0] == 2'b00));

    // R9
    x_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_i && (op_i == 3'd0 || op_i == 3'd5 || op_i == 3'd6)) |=> (ccr_o[4] == $past(ccr_o[4])));

    // R11
    shift_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_i && op_i == 3'd7) |=> (ccr_o[0] == $past(sh_carry_i)) && (ccr_o[4] == ccr_o[0]));

    // R3
    x_tracks_c_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_i && op_i >= 3'd1 && op_i <= 3'd4) |=> (ccr_o[4] == ccr_o[0]));

endmodule

// File: tb/tb_ccg_flags_top.sv
module tb_ccg_flags_top;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        upd_i = 1'b0;
    logic [2:0]  op_i = 3'd0;
    logic [31:0] op_a_i = '0;
    logic [31:0] op_b_i = '0;
    logic        sh_carry_i = 1'b0;
    logic [31:0] res_o;
    logic [4:0]  ccr_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [4:0] exp_ccr = 5'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ccg_flags_top dut (
        .clk(clk), .rst_n(rst_n), .upd_i(upd_i), .op_i(op_i),
        .op_a_i(op_a_i), .op_b_i(op_b_i), .sh_carry_i(sh_carry_i),
        .res_o(res_o), .ccr_o(ccr_o)
    );

    function automatic string tag_of(input logic [2:0] op);
        case (op)
            3'd0: return "R10";
            3'd1: return "R3";
            3'd2: return "R4";
            3'd3: return "R5";
            3'd4: return "R6";
            3'd7: return "R11";
            default: return "R9";
        endcase
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Behavioural model: returns expected result and next flags
    task automatic model(input logic [2:0] op, input logic [31:0] a, input logic [31:0] b,
                         input logic sc, input logic [4:0] prev,
                         output logic [31:0] r, output logic [4:0] nf);
        longint ua, ub, ur, m;
        int w;
        logic xo, n, z, v, c, x;
        bit sa, sb, sr;
        xo = prev[4];
        x = xo;
        w = 32;
        if (op == 3'd5) w = 8;
        if (op == 3'd6) w = 16;
        m = (longint'(1) << w) - 1;
        ua = longint'(a) & m;
        ub = longint'(b) & m;
        v = 0; c = 0;
        case (op)
            3'd1, 3'd3: begin
                ur = (ua + ub + ((op == 3'd3 && xo) ? 1 : 0)) & m;
                c = (op == 3'd3 && xo) ? (ur <= ub) : (ur < ub);
            end
            3'd2, 3'd4, 3'd5, 3'd6: begin
                ur = (ua - ub - ((op == 3'd4 && xo) ? 1 : 0)) & m;
                c = (op == 3'd4 && xo) ? (ua <= ub) : (ua < ub);
            end
            default: ur = ua;
        endcase
        sa = ua[w-1]; sb = ub[w-1]; sr = ur[w-1];
        if (op == 3'd1 || op == 3'd3) v = (sa == sb) && (sr != sa);
        if (op == 3'd2 || op == 3'd4 || op == 3'd5 || op == 3'd6) v = (sa != sb) && (sr != sa);
        if (op == 3'd7) c = sc;
        z = (ur == 0);
        n = sr;
        if (op == 3'd3 || op == 3'd4) z = prev[2] & z;
        if (op >= 3'd1 && op <= 3'd4) x = c;
        if (op == 3'd7) x = c;
        nf = {x, n, z, v, c};
        if (op == 3'd5 || op == 3'd6) r = a - b;
        else r = ur[31:0];
    endtask

    task automatic step(input logic [2:0] op, input logic [31:0] a, input logic [31:0] b,
                        input logic sc, input logic up);
        logic [31:0] er;
        logic [4:0]  nf;
        @(negedge clk);
        op_i = op; op_a_i = a; op_b_i = b; sh_carry_i = sc; upd_i = up;
        #1;
        model(op, a, b, sc, exp_ccr, er, nf);
        check({tag_of(op), " result"}, res_o, er);
        @(posedge clk);
        #1;
        if (up) exp_ccr = nf;
        check(up ? {tag_of(op), " flags"} : "R2 hold", {27'b0, ccr_o}, {27'b0, exp_ccr});
        check("R8 N/Z exclusive", {31'b0, ccr_o[3] & ccr_o[2]}, 32'd0);
    endtask

    initial begin : watchdog
        for (int i = 0; i < WATCHDOG; i++) begin
            @(posedge clk);
            if (done) disable watchdog;
        end
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R1 reset", {27'b0, ccr_o}, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("R1 after release", {27'b0, ccr_o}, 32'd0);

        // R3: wrap to zero, carry without overflow; then signed overflow
        step(3'd1, 32'hFFFF_FFFF, 32'h0000_0001, 1'b0, 1'b1);
        step(3'd1, 32'h7FFF_FFFF, 32'h0000_0001, 1'b0, 1'b1);
        // R5: X=0 now; then produce X=1 and use equal-result carry
        step(3'd2, 32'h0000_0000, 32'h0000_0001, 1'b0, 1'b1);   // R4 borrow, X=1
        step(3'd3, 32'hFFFF_FFFF, 32'h0000_0000, 1'b0, 1'b1);   // R5 res 0 <= b
        // R6: X=1, equal operands borrow
        step(3'd4, 32'h0000_0005, 32'h0000_0005, 1'b0, 1'b1);
        // R4: equal operands, X clear after a plain sub
        step(3'd2, 32'h0000_0005, 32'h0000_0005, 1'b0, 1'b1);   // Z=1, X=0
        step(3'd4, 32'h0000_0005, 32'h0000_0005, 1'b0, 1'b1);   // R6 X=0: no borrow, Z stays
        // R7: sticky Z chain
        step(3'd3, 32'h0000_0000, 32'h0000_0000, 1'b0, 1'b1);   // Z kept 1
        step(3'd3, 32'h0000_0001, 32'h0000_0002, 1'b0, 1'b1);   // Z cleared
        step(3'd3, 32'h0000_0000, 32'h0000_0000, 1'b0, 1'b1);   // R7 Z stays 0
        // R9: narrow compares with conflicting upper bits
        step(3'd5, 32'h1234_5680, 32'hABCD_EF01, 1'b0, 1'b1);
        step(3'd5, 32'hFFFF_FF10, 32'h0000_0010, 1'b0, 1'b1);
        step(3'd6, 32'h0001_8000, 32'h0000_0001, 1'b0, 1'b1);
        step(3'd6, 32'hAAAA_0003, 32'h5555_0004, 1'b0, 1'b1);
        // R10 / R11
        step(3'd0, 32'h8000_0000, 32'h0, 1'b0, 1'b1);
        step(3'd0, 32'h0000_0000, 32'h0, 1'b1, 1'b1);
        step(3'd7, 32'h0000_0000, 32'h0, 1'b1, 1'b1);
        step(3'd7, 32'hC000_0000, 32'h0, 1'b0, 1'b1);
        // R2: strobe low keeps flags
        step(3'd1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1, 1'b0);
        step(3'd7, 32'h0, 32'h0, 1'b1, 1'b0);

        for (int i = 0; i < 400; i++) begin
            logic [31:0] a, b;
            a = $urandom;
            b = $urandom;
            if (($urandom % 4) == 0) b = a;
            if (($urandom % 5) == 0) a = a & 32'h0000_00FF;
            step(3'($urandom % 8), a, b, 1'($urandom), ($urandom % 4) != 0);
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule